// File: doc/BRIEF.md
# Address Security Attribution Unit

This block labels every address with a security attribute: Secure, Non-Secure, or Non-Secure Callable (a secure area that non-secure code may branch into as an entry point). Two sources decide the label. The first is a small fixed region map set when the chip is built. It can be removed with a parameter. The second is a table of programmable regions. Software in the secure world writes this table through a simple register port.

The lookup path is purely combinational. A requester presents an address, a valid strobe and a flag that says whether it runs in the secure world. In the same cycle the block returns the attribute, a hit flag and a violation pulse. A lookup is never stalled, so the lookup path has no back-pressure and uses no ready signal. The register port is synchronous: a write takes effect at the clock edge where the write strobe is high, and read data is returned combinationally in the same cycle.

Top module: `sec_attr_unit`

## Requirements
- R1: `lk_attr` is coded 2'b00 Secure, 2'b01 Non-Secure and 2'b10 Non-Secure Callable. The code 2'b11 is never produced. The attribute is valid in the same cycle as `lk_addr`.
- R2: Register map, indexed by `cfg_addr` in words. Word 0 is the control register, with the global enable in bit 0. For region i, word 2+2i holds the base in bits [31:5]. Word 3+2i holds the limit in bits [31:5], the callable flag in bit 1 and the region enable in bit 0. All other bits and words read as zero. An enabled region matches addresses from its base up to its limit with the low five bits set, inclusive. When the global enable is set and exactly one region matches, the result is Non-Secure, or Non-Secure Callable if that region's callable flag is set, and `lk_hit` is 1.
- R3: An address that matches no region in either source gives Secure with `lk_hit` = 0.
- R4: Register writes with `cfg_secure` = 0 are ignored. Reads with `cfg_secure` = 0 return zero.
- R5: A matching programmable region overrides the fixed map's attribute.
- R6: With `FIXED_MAP_EN` = 1, the fixed map holds four regions, each giving `lk_hit` = 1:
  - 0x0000_0000–0x0FFF_FFFF Secure
  - 0x1000_0000–0x1000_FFFF Non-Secure Callable
  - 0x2000_0000–0x3FFF_FFFF Non-Secure
  - 0x4000_0000–0x4FFF_FFFF Non-Secure
- R7: When two or more enabled programmable regions match, the result is Secure with `lk_hit` = 1.
- R8: When the global enable is clear, programmable regions are ignored. Addresses outside the fixed map are then Secure, or Non-Secure if `DISABLED_NS` = 1.
- R9: Reset clears the global enable and every region register, so all of them read back as zero.
- R10: `lk_violation` is 1 only when `lk_valid` is 1, `lk_secure` is 0 and the attribute is Secure. Non-Secure and callable results never flag a violation.
- R11: A region whose enable bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_secure | input | 1 | Register access comes from the secure world |
| cfg_addr | input | CFG_AW | Register word index |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rdata | output | ADDR_W | Read data, zero when not permitted |
| lk_valid | input | 1 | Lookup request valid |
| lk_secure | input | 1 | Requester is in the secure world |
| lk_addr | input | ADDR_W | Lookup address |
| lk_attr | output | 2 | Attribute code |
| lk_hit | output | 1 | Some region matched |
| lk_violation | output | 1 | Non-secure access to a Secure address |

## Verification
`lk_attr`, `lk_hit` and `lk_violation` respond within the same cycle as the lookup inputs. `cfg_rdata` also responds in the same cycle as `cfg_rd`. A register write becomes visible only after the rising edge that captures it. The bench therefore drives every input on the falling edge. It applies writes for exactly one rising edge, and it samples combinational results one nanosecond after each input change, which is well away from any edge. Each lookup that follows a write is sampled only after the capturing edge has passed.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    ATTR_SEC  = 2'b00,
    ATTR_NS   = 2'b01,
    ATTR_NSC  = 2'b10
  } attr_e;

  localparam int FIX_N = 4;

  function automatic logic [31:0] fix_lo(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h1000_0000;
      2: return 32'h2000_0000;
      default: return 32'h4000_0000;
    endcase
  endfunction

  function automatic logic [31:0] fix_hi(input int i);
    case (i)
      0: return 32'h0FFF_FFFF;
      1: return 32'h1000_FFFF;
      2: return 32'h3FFF_FFFF;
      default: return 32'h4FFF_FFFF;
    endcase
  endfunction

  function automatic attr_e fix_attr(input int i);
    case (i)
      0: return ATTR_SEC;
      1: return ATTR_NSC;
      default: return ATTR_NS;
    endcase
  endfunction
endpackage

// File: rtl/sau_cfg_regs.sv
module sau_cfg_regs #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 8,
  parameter int GRAN_BITS   = 5,
  localparam int GW         = ADDR_W - GRAN_BITS,
  localparam int CFG_AW     = $clog2(2 * NUM_REGIONS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_secure,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              glob_en,
  output logic [GW-1:0]     base_o [NUM_REGIONS],
  output logic [GW-1:0]     lim_o  [NUM_REGIONS],
  output logic [NUM_REGIONS-1:0] nsc_o,
  output logic [NUM_REGIONS-1:0] en_o
);
  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[GRAN_BITS-1:2];

  logic wr_ok;
  assign wr_ok = cfg_wr && cfg_secure;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
        base_o[r] <= '0;
        lim_o[r]  <= '0;
        nsc_o[r]  <= 1'b0;
        en_o[r]   <= 1'b0;
      end
    end else if (wr_ok) begin
      if (int'(cfg_addr) == 0) glob_en <= cfg_wdata[0];
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (int'(cfg_addr) == 2 + 2 * r) base_o[r] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
        if (int'(cfg_addr) == 3 + 2 * r) begin
          lim_o[r] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
          nsc_o[r] <= cfg_wdata[1];
          en_o[r]  <= cfg_wdata[0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd && cfg_secure) begin
      if (int'(cfg_addr) == 0) cfg_rdata[0] = glob_en;
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (int'(cfg_addr) == 2 + 2 * r)
          cfg_rdata = {base_o[r], {GRAN_BITS{1'b0}}};
        if (int'(cfg_addr) == 3 + 2 * r)
          cfg_rdata = {lim_o[r], {(GRAN_BITS-2){1'b0}}, nsc_o[r], en_o[r]};
      end
    end
  end
endmodule

// File: rtl/sau_region_match.sv
module sau_region_match #(
  parameter int GW = 27
) (
  input  logic          en,
  input  logic [GW-1:0] blk,
  input  logic [GW-1:0] base,
  input  logic [GW-1:0] lim,
  output logic          match
);
  assign match = en && (blk >= base) && (blk <= lim);
endmodule

// File: rtl/sau_fixed_map.sv
module sau_fixed_map
  import sau_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter bit FIXED_MAP_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              fix_hit,
  output attr_e             fix_attr_o
);
  generate
    if (FIXED_MAP_EN) begin : g_map
      logic [FIX_N-1:0] hit_v;
      for (genvar i = 0; i < FIX_N; i++) begin : g_reg
        assign hit_v[i] = (32'(addr) >= fix_lo(i)) && (32'(addr) <= fix_hi(i));
      end
      always_comb begin
        fix_attr_o = ATTR_SEC;
        for (int i = 0; i < FIX_N; i++)
          if (hit_v[i]) fix_attr_o = fix_attr(i);
      end
      assign fix_hit = |hit_v;
    end else begin : g_none
      logic unused_addr;
      assign unused_addr = ^addr;
      assign fix_hit     = 1'b0;
      assign fix_attr_o  = ATTR_SEC;
    end
  endgenerate
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_REGIONS  = 8,
  parameter bit FIXED_MAP_EN = 1'b1,
  parameter bit DISABLED_NS  = 1'b0,
  localparam int GRAN_BITS   = 5,
  localparam int GW          = ADDR_W - GRAN_BITS,
  localparam int CFG_AW      = $clog2(2 * NUM_REGIONS + 2),
  localparam int CNT_W       = $clog2(NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_secure,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              lk_valid,
  input  logic              lk_secure,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_attr,
  output logic              lk_hit,
  output logic              lk_violation
);
  logic                   glob_en;
  logic [GW-1:0]          base_q [NUM_REGIONS];
  logic [GW-1:0]          lim_q  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] nsc_q, en_q, prog_match;
  logic                   fix_hit;
  attr_e                  fix_attr_w, attr_w;
  logic [CNT_W-1:0]       n_match;
  logic                   sel_nsc;

  sau_cfg_regs #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .GRAN_BITS(GRAN_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_secure(cfg_secure),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .glob_en(glob_en),
    .base_o(base_q), .lim_o(lim_q), .nsc_o(nsc_q), .en_o(en_q)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    sau_region_match #(.GW(GW)) match_i (
      .en(en_q[r]), .blk(lk_addr[ADDR_W-1:GRAN_BITS]),
      .base(base_q[r]), .lim(lim_q[r]), .match(prog_match[r])
    );
  end

  sau_fixed_map #(.ADDR_W(ADDR_W), .FIXED_MAP_EN(FIXED_MAP_EN)) fix_i (
    .addr(lk_addr), .fix_hit(fix_hit), .fix_attr_o(fix_attr_w)
  );

  always_comb begin
    n_match = '0;
    sel_nsc = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      n_match = n_match + CNT_W'(prog_match[r]);
      if (prog_match[r]) sel_nsc = nsc_q[r];
    end
  end

  always_comb begin
    if (glob_en && n_match > CNT_W'(1)) begin
      attr_w = ATTR_SEC;  lk_hit = 1'b1;
    end else if (glob_en && n_match == CNT_W'(1)) begin
      attr_w = sel_nsc ? ATTR_NSC : ATTR_NS;  lk_hit = 1'b1;
    end else if (fix_hit) begin
      attr_w = fix_attr_w;  lk_hit = 1'b1;
    end else begin
      attr_w = (!glob_en && DISABLED_NS) ? ATTR_NS : ATTR_SEC;  lk_hit = 1'b0;
    end
  end

  assign lk_attr      = attr_w;
  assign lk_violation = lk_valid && !lk_secure && (attr_w == ATTR_SEC);
endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
  parameter int NUM_REGIONS = 8,
  parameter bit DISABLED_NS = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_rd,
  input logic                   cfg_secure,
  input logic [31:0]            cfg_rdata,
  input logic                   lk_valid,
  input logic                   lk_secure,
  input logic [1:0]             lk_attr,
  input logic                   lk_hit,
  input logic                   lk_violation,
  input logic                   glob_en,
  input logic [NUM_REGIONS-1:0] match_vec
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    lk_attr != 2'b11);
  a_r3_unmatched_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit && (glob_en || !DISABLED_NS)) |-> lk_attr == 2'b00);
  a_r4_ns_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !cfg_secure) |-> cfg_rdata == '0);
  a_r7_overlap_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && $countones(match_vec) > 1) |-> (lk_attr == 2'b00 && lk_hit));
  a_r10_viol_ns_only: assert property (@(posedge clk) disable iff (!rst_n)
    lk_violation |-> (lk_valid && !lk_secure));
  a_r10_no_viol_open: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_attr != 2'b00) |-> !lk_violation);
endmodule

bind sec_attr_unit sau_checker #(.NUM_REGIONS(NUM_REGIONS), .DISABLED_NS(DISABLED_NS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_secure(cfg_secure), .cfg_rdata(cfg_rdata),
  .lk_valid(lk_valid), .lk_secure(lk_secure), .lk_attr(lk_attr), .lk_hit(lk_hit),
  .lk_violation(lk_violation), .glob_en(glob_en), .match_vec(prog_match)
);

// File: tb/sec_attr_unit_tb_top.sv
module sec_attr_unit_tb_top;
  localparam logic [1:0] SEC = 2'b00, NS = 2'b01, NSC = 2'b10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_rd = 0, cfg_secure = 0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        lk_valid = 0, lk_secure = 0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_attr;
  logic        lk_hit, lk_violation;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sec_attr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_secure(cfg_secure),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_secure(lk_secure), .lk_addr(lk_addr),
    .lk_attr(lk_attr), .lk_hit(lk_hit), .lk_violation(lk_violation)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sec, input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_secure = sec; cfg_addr = 5'(a); cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic sec, input int a, input logic [31:0] exp);
    @(negedge clk);
    cfg_secure = sec; cfg_addr = 5'(a); cfg_rd = 1;
    #1 check(req, cfg_rdata, exp);
    cfg_rd = 0;
  endtask

  task automatic lk_chk(input string req, input logic [31:0] a, input logic sec,
                        input logic [1:0] exp_attr, input logic exp_hit, input logic exp_viol);
    @(negedge clk);
    lk_addr = a; lk_secure = sec; lk_valid = 1;
    #1;
    check({req, " attr"}, 32'(lk_attr), 32'(exp_attr));
    check({req, " hit"}, 32'(lk_hit), 32'(exp_hit));
    check({req, " viol"}, 32'(lk_violation), 32'(exp_viol));
    lk_valid = 0;
  endtask

  task automatic t_reset();
    rd_chk("R9 ctrl", 1, 0, 0);
    rd_chk("R9 lim0", 1, 3, 0);
    lk_chk("R3 unmatched", 32'h8000_0000, 1, SEC, 0, 0);
  endtask

  task automatic t_fixed();
    lk_chk("R6 sec", 32'h0000_1000, 1, SEC, 1, 0);
    lk_chk("R6 nsc", 32'h1000_0040, 0, NSC, 1, 0);
    lk_chk("R6 ns lo", 32'h2000_0000, 0, NS, 1, 0);
    lk_chk("R6 ns hi", 32'h4FFF_FFFF, 0, NS, 1, 0);
    lk_chk("R1 same cycle", 32'h5000_0000, 1, SEC, 0, 0);
  endtask

  task automatic t_ns_cfg();
    wr(0, 0, 1);
    rd_chk("R4 ns write ignored", 1, 0, 0);
    wr(0, 3, 32'h8000_0FE1);
    rd_chk("R4 ns write ignored lim", 1, 3, 0);
  endtask

  task automatic t_prog();
    wr(1, 2, 32'h8000_0000);
    wr(1, 3, 32'h8000_0FE1);
    wr(1, 0, 1);
    rd_chk("R2 base readback", 1, 2, 32'h8000_0000);
    rd_chk("R2 lim readback", 1, 3, 32'h8000_0FE1);
    rd_chk("R4 ns read zero", 0, 3, 0);
    lk_chk("R2 top of limit", 32'h8000_0FFF, 0, NS, 1, 0);
    lk_chk("R3 past limit", 32'h8000_1000, 1, SEC, 0, 0);
    lk_chk("R10 ns to secure", 32'h8000_1000, 0, SEC, 0, 1);
    wr(1, 4, 32'h9000_0000);
    wr(1, 5, 32'h9000_0003);
    lk_chk("R2 nsc region", 32'h9000_001F, 0, NSC, 1, 0);
    lk_chk("R5 override", 32'h0000_0100, 0, SEC, 1, 1);
    wr(1, 6, 32'h0000_0000);
    wr(1, 7, 32'h0000_0FE1);
    lk_chk("R5 override", 32'h0000_0100, 0, NS, 1, 0);
    wr(1, 8, 32'h8000_0800);
    wr(1, 9, 32'h8000_08E1);
    lk_chk("R7 overlap", 32'h8000_0820, 0, SEC, 1, 1);
    wr(1, 10, 32'hA000_0000);
    wr(1, 11, 32'hA000_0FE2);
    lk_chk("R11 disabled", 32'hA000_0000, 0, SEC, 0, 1);
    rd_chk("R11 readback", 1, 11, 32'hA000_0FE2);
  endtask

  task automatic t_global_off();
    wr(1, 0, 0);
    lk_chk("R8 prog ignored", 32'h8000_0010, 1, SEC, 0, 0);
    lk_chk("R8 fixed kept", 32'h2000_0000, 0, NS, 1, 0);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_chk("R9 cleared base", 1, 2, 0);
    rd_chk("R9 cleared lim", 1, 3, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fixed();
    t_ns_cfg();
    t_prog();
    t_global_off();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule